// File: doc/BRIEF.md
# Forwarded-Clock Four-Lane Deserializer

This block rebuilds a 28-bit parallel word from four serial data lanes. A fifth lane carries a frame clock at word rate, forwarded next to the data. All five lanes are sampled once per bit period by a local bit-rate clock. A low-to-high step on the sampled clock lane marks the first bit slot of a frame. Each lane delivers seven bits per frame, and these bits are collected into the output word.

Words reach the output only while the block is locked. Lock is declared once enough frame-clock edges have arrived in a row, each exactly seven slots after the one before. A missing edge or an early edge drops lock at once and starts a new chain. When the forwarded clock stops, the last published word stays on the output and the strobe goes quiet. An active-low power-down input forces the data output, the strobe and the lock flag low.

Top module: `fwdclk_deser`

## Requirements
- R1: A clock-lane sample of 1 that follows a sample of 0 marks bit slot 0. The data-lane samples taken in that same cycle are the first bits of the frame, and the slots that follow are numbered 1 to 6.
- R2: The bit of lane k in slot s (k = 0..3, s = 0..6) appears at word_o bit 7k+s. The first bit of lane k therefore lands on bit 7k.
- R3: word_o takes a new word only in the cycle that strobe_o rises, two clock edges after the edge that samples slot 6. Every word of a locked frame is delivered, in order.
- R4: strobe_o rises once per published frame and stays high for STB_HIGH cycles (3 by default). It never rises while lock is absent.
- R5: lock_o asserts when the LOCK_FRAMES-th edge of an unbroken chain is seen. A chain is a run of edges spaced exactly seven slots apart. Frames 1 to LOCK_FRAMES-1 of a chain are not published, and frame LOCK_FRAMES is the first one that is.
- R6: If no rising clock-lane edge appears seven slots after the previous one, lock_o clears. word_o then keeps its last published value, and strobe_o stays low for as long as the clock stays stopped.
- R7: A rising edge that arrives before slot 6 has passed is a phase slip. It clears lock_o, and that edge becomes frame 1 of a new chain. A late edge behaves as a missing edge followed by a new chain.
- R8: From the first clock edge at which pwr_n is sampled low, word_o is all zeros and strobe_o and lock_o are low. After pwr_n returns high, lock must be acquired again from a new chain.
- R9: While rst_n is sampled low, word_o is zero and strobe_o and lock_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| lane_i | input | 4 | Serial data lanes, one bit per clock |
| fclk_i | input | 1 | Forwarded frame-clock lane, sampled at bit rate |
| word_o | output | 28 | Recovered parallel word |
| strobe_o | output | 1 | Word strobe; its rising edge marks a new valid word |
| lock_o | output | 1 | Frame alignment locked |

## Verification
The block is driven by a serializer model. The words sent are a walking one, all zeros, all ones, two alternating-bit patterns and random values. The walking one finds any mistake in lane or slot mapping, because each bit position can only be reached one way. The alternating patterns expose a shift that is off by one slot. The clock-lane stimulus includes a fresh chain, a stopped clock, a late slip, an early slip (a truncated frame) and a power-down window. Together these show whether words are published too early, at a lost boundary, or during power-down.

// File: rtl/deser_pkg.sv
// Shared definitions for the forwarded-clock deserializer.
package deser_pkg;

    // Classification of the clock lane in one sampling cycle.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,  // mid-frame, no edge expected or seen
        EV_GOOD  = 2'd1,  // edge exactly one frame after the previous edge
        EV_EARLY = 2'd2,  // edge before the frame was complete
        EV_MISS  = 2'd3   // frame complete but no edge arrived
    } edge_ev_t;

endpackage

// File: rtl/deser_lane_capture.sv
// Input sampling stage.
// Registers the data lanes and the clock lane once per bit period, then
// flags a rising edge on the clock lane.
// Assumes all lanes are already aligned to clk by the analog front end.
module deser_lane_capture #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_i,
    input  logic             fclk_i,
    output logic [LANES-1:0] lane_q,
    output logic             rise_o
);

    logic fclk_q;
    logic fclk_d;

    // Sample every lane and keep one older clock-lane sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            fclk_q <= 1'b0;
            fclk_d <= 1'b0;
        end else begin
            lane_q <= lane_i;
            fclk_q <= fclk_i;
            fclk_d <= fclk_q;
        end
    end

    // A sample of 1 that follows a sample of 0 marks the first slot of a frame.
    assign rise_o = fclk_q & ~fclk_d;

endmodule

// File: rtl/deser_frame_align.sv
// Frame aligner and lock tracker.
// Numbers the bit slots from the clock-lane edge and counts the chain of
// edges that are spaced one frame apart.
// Assumes LOCK_FRAMES >= 2.
module deser_frame_align
    import deser_pkg::*;
#(
    parameter int BITS        = 7,
    parameter int LOCK_FRAMES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_n,
    input  logic rise_i,
    output logic last_o,
    output logic lock_o
);

    localparam int SLOT_W = $clog2(BITS);
    localparam int CNT_W  = $clog2(LOCK_FRAMES + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BITS - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(LOCK_FRAMES);

    logic [SLOT_W-1:0] slot_r;
    logic [SLOT_W-1:0] cur_slot;
    logic [CNT_W-1:0]  cnt;
    edge_ev_t          ev;

    // Slot number of the sample now being shifted in.
    always_comb begin
        if (rise_i || slot_r == LAST_SLOT) cur_slot = '0;
        else                               cur_slot = slot_r + 1'b1;
    end

    // Decide whether this cycle's edge, or its absence, fits the frame.
    always_comb begin
        if (rise_i)                  ev = (slot_r == LAST_SLOT) ? EV_GOOD : EV_EARLY;
        else if (slot_r == LAST_SLOT) ev = EV_MISS;
        else                         ev = EV_NONE;
    end

    assign last_o = (cur_slot == LAST_SLOT);

    // Slot counter runs freely and realigns on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_r <= LAST_SLOT;
        else        slot_r <= cur_slot;
    end

    // Chain length and lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_n) begin
            cnt    <= '0;
            lock_o <= 1'b0;
        end else begin
            case (ev)
                EV_GOOD: begin
                    if (cnt != CNT_MAX)           cnt    <= cnt + 1'b1;
                    if (cnt == CNT_MAX - 1'b1)    lock_o <= 1'b1;
                end
                EV_EARLY: begin
                    cnt    <= CNT_W'(1);
                    lock_o <= 1'b0;
                end
                EV_MISS: begin
                    cnt    <= '0;
                    lock_o <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R1: an edge always restarts slot numbering at zero.
    a_r1_edge_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> (slot_r == '0));

    // R6: a frame ending without an edge leaves the block unlocked.
    a_r6_miss_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_r == LAST_SLOT && !rise_i) |=> !lock_o);

    // R7: an early edge unlocks and starts a chain of one.
    a_r7_early_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && slot_r != LAST_SLOT && pwr_n) |=> (!lock_o && cnt == CNT_W'(1)));

    // R5: lock appears only when the chain reaches its required length.
    a_r5_lock_after_chain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(cnt) == CNT_MAX - 1'b1));

endmodule

// File: rtl/deser_lane_shift.sv
// Per-lane shift registers.
// Every cycle, each lane's newest sample enters at the top and older
// samples move toward bit 0. When slot 6 has just been captured, bit s
// of a lane holds slot s.
// Assumes the aligner says when a frame is complete.
module deser_lane_shift #(
    parameter int LANES = 4,
    parameter int BITS  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      lane_q,
    output logic [LANES*BITS-1:0] frame_o
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [BITS-1:0] sh;

        // Shift the newest lane sample in from the top.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {lane_q[k], sh[BITS-1:1]};
        end

        assign frame_o[k*BITS +: BITS] = sh;
    end

endmodule

// File: rtl/deser_word_out.sv
// Output register and strobe generator.
// Copies the assembled frame to the output one cycle after its last slot,
// provided the link is locked. The strobe rises together with the new word.
// Power-down clears the output and the strobe.
// Assumes STB_HIGH < BITS, so each strobe pulse ends before the next frame.
module deser_word_out #(
    parameter int WIDTH    = 28,
    parameter int STB_HIGH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_n,
    input  logic             last_i,
    input  logic             lock_i,
    input  logic [WIDTH-1:0] frame_i,
    output logic [WIDTH-1:0] word_o,
    output logic             strobe_o
);

    localparam int STB_W = $clog2(STB_HIGH + 1);
    localparam logic [STB_W-1:0] STB_LOAD = STB_W'(STB_HIGH);

    logic             pub_r;
    logic [STB_W-1:0] stb_cnt;

    // Mark a locked frame whose last slot was just shifted in.
    always_ff @(posedge clk) begin
        if (!rst_n) pub_r <= 1'b0;
        else        pub_r <= last_i && lock_i && pwr_n;
    end

    // Hold the published word; power-down forces zeros.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_n) word_o <= '0;
        else if (pub_r)       word_o <= frame_i;
    end

    // Strobe pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_n)   stb_cnt <= '0;
        else if (pub_r)         stb_cnt <= STB_LOAD;
        else if (stb_cnt != '0) stb_cnt <= stb_cnt - 1'b1;
    end

    assign strobe_o = (stb_cnt != '0);

    // R8: power-down clears the word and the strobe.
    a_r8_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> (word_o == '0 && !strobe_o));

    // R3: outside power-down, the word changes only as the strobe rises.
    a_r3_word_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_n) && word_o != $past(word_o)) |-> $rose(strobe_o));

endmodule

// File: rtl/fwdclk_deser.sv
// Forwarded-clock four-lane deserializer, top level.
// Chain: input sampling -> slot alignment and lock -> lane shifting ->
// output register with strobe.
// Assumes clk runs at bit rate with lanes already aligned to it, and that
// reset is held for at least two cycles.
module fwdclk_deser #(
    parameter int LANES       = 4,
    parameter int BITS        = 7,
    parameter int LOCK_FRAMES = 64,
    parameter int STB_HIGH    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_n,
    input  logic [LANES-1:0]      lane_i,
    input  logic                  fclk_i,
    output logic [LANES*BITS-1:0] word_o,
    output logic                  strobe_o,
    output logic                  lock_o
);

    localparam int WIDTH = LANES * BITS;

    logic [LANES-1:0] lane_q;
    logic             rise;
    logic             last;
    logic [WIDTH-1:0] frame;

    deser_lane_capture #(.LANES(LANES)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane_i (lane_i),
        .fclk_i (fclk_i),
        .lane_q (lane_q),
        .rise_o (rise)
    );

    deser_frame_align #(.BITS(BITS), .LOCK_FRAMES(LOCK_FRAMES)) u_align (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_n  (pwr_n),
        .rise_i (rise),
        .last_o (last),
        .lock_o (lock_o)
    );

    deser_lane_shift #(.LANES(LANES), .BITS(BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_q  (lane_q),
        .frame_o (frame)
    );

    deser_word_out #(.WIDTH(WIDTH), .STB_HIGH(STB_HIGH)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_n    (pwr_n),
        .last_i   (last),
        .lock_i   (lock_o),
        .frame_i  (frame),
        .word_o   (word_o),
        .strobe_o (strobe_o)
    );

    // R9: reset leaves every output quiet.
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (word_o == '0 && !strobe_o && !lock_o));

endmodule

// File: tb/fwdclk_deser_tb_top.sv
module fwdclk_deser_tb_top;

    localparam int LOCKN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_n = 1'b1;
    logic [3:0]  lane_i = '0;
    logic        fclk_i = 1'b0;
    logic [27:0] word_o;
    logic        strobe_o;
    logic        lock_o;

    int checks = 0;
    int errors = 0;
    logic [27:0] exp_q[$];
    logic [27:0] mon_exp;
    logic [27:0] last_sent;
    logic        stb_prev = 1'b0;

    always #2 clk = ~clk;

    fwdclk_deser #(.LOCK_FRAMES(LOCKN)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .lane_i(lane_i),
        .fclk_i(fclk_i), .word_o(word_o), .strobe_o(strobe_o), .lock_o(lock_o)
    );

    task automatic chk(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Serializer model: slots 0..3 clock high, 4..6 low; lane k slot s = bit 7k+s.
    task automatic send_slots(input logic [27:0] w, input int nslots);
        for (int s = 0; s < nslots; s++) begin
            @(negedge clk);
            fclk_i = (s < 4);
            for (int k = 0; k < 4; k++) lane_i[k] = w[k*7+s];
        end
    endtask

    task automatic send_frame(input logic [27:0] w, input bit expect_pub);
        if (expect_pub) begin
            exp_q.push_back(w);
            last_sent = w;
        end
        send_slots(w, 7);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fclk_i = 1'b0;
            lane_i = 4'($urandom);
        end
    endtask

    function automatic logic [27:0] rnd();
        return 28'($urandom);
    endfunction

    // Scoreboard monitor: each strobe rise pops one expected word (R2, R3, R4).
    always @(negedge clk) begin
        if (rst_n && strobe_o && !stb_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected strobe", word_o, 28'h0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk(word_o == mon_exp, "R2 word mapping", word_o, mon_exp);
            end
        end
        stb_prev = strobe_o;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R3 watchdog expired", 28'h0, 28'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(word_o == 0 && !strobe_o && !lock_o, "R9 reset outputs", {25'h0, word_o[0], strobe_o, lock_o}, 28'h0);
        rst_n = 1'b1;
        idle(5);
        chk(word_o == 0 && !lock_o, "R9 idle after reset", {27'h0, lock_o}, 28'h0);

        // Fresh chain: first LOCKN-1 frames not published (R5)
        for (int i = 0; i < LOCKN - 1; i++) send_frame(rnd(), 1'b0);
        chk(lock_o == 1'b0, "R5 no lock before chain", {27'h0, lock_o}, 28'h0);
        send_frame(28'h0000001, 1'b1);
        chk(lock_o == 1'b1, "R5 lock at chain length", {27'h0, lock_o}, 28'h1);
        // R1/R2: walking one over every position
        for (int b = 1; b < 28; b++) send_frame(28'h1 << b, 1'b1);
        send_frame(28'h0000000, 1'b1);
        send_frame(28'hFFFFFFF, 1'b1);
        send_frame(28'h5555555, 1'b1);
        send_frame(28'hAAAAAAA, 1'b1);
        for (int i = 0; i < 8; i++) send_frame(rnd(), 1'b1);

        // R6: forwarded clock stops
        idle(12);
        chk(exp_q.size() == 0, "R3 all words delivered", 28'(exp_q.size()), 28'h0);
        chk(lock_o == 1'b0, "R6 lock lost on stop", {27'h0, lock_o}, 28'h0);
        chk(word_o == last_sent, "R6 word held", word_o, last_sent);
        idle(25);
        chk(word_o == last_sent && !strobe_o, "R6 word still held", word_o, last_sent);

        // Relock, then late slip (R7)
        for (int i = 0; i < LOCKN - 1; i++) send_frame(rnd(), 1'b0);
        for (int i = 0; i < 3; i++) send_frame(rnd(), 1'b1);
        chk(lock_o == 1'b1, "R7 relocked", {27'h0, lock_o}, 28'h1);
        idle(3);
        for (int i = 0; i < LOCKN - 1; i++) send_frame(rnd(), 1'b0);
        chk(lock_o == 1'b0, "R7 unlocked after late slip", {27'h0, lock_o}, 28'h0);
        for (int i = 0; i < 3; i++) send_frame(rnd(), 1'b1);

        // Early slip: truncated frame (R7)
        send_slots(rnd(), 5);
        chk(lock_o == 1'b1, "R7 lock before early edge", {27'h0, lock_o}, 28'h1);
        for (int i = 0; i < LOCKN - 1; i++) send_frame(rnd(), 1'b0);
        chk(lock_o == 1'b0, "R7 unlocked after early slip", {27'h0, lock_o}, 28'h0);
        for (int i = 0; i < 3; i++) send_frame(rnd(), 1'b1);
        chk(lock_o == 1'b1, "R7 relock after early slip", {27'h0, lock_o}, 28'h1);

        // Power-down (R8)
        idle(4);
        chk(word_o == last_sent, "R8 word before power-down", word_o, last_sent);
        pwr_n = 1'b0;
        for (int i = 0; i < 3; i++) send_frame(rnd(), 1'b0);
        chk(word_o == 0, "R8 word low", word_o, 28'h0);
        chk(!strobe_o && !lock_o, "R8 strobe and lock low", {26'h0, strobe_o, lock_o}, 28'h0);
        pwr_n = 1'b1;
        for (int i = 0; i < LOCKN - 1; i++) send_frame(rnd(), 1'b0);
        chk(lock_o == 1'b0 && word_o == 0, "R8 relock needed", word_o, 28'h0);
        for (int i = 0; i < 3; i++) send_frame(rnd(), 1'b1);
        idle(12);
        chk(exp_q.size() == 0, "R3 final queue empty", 28'(exp_q.size()), 28'h0);
        chk(word_o == last_sent, "R6 final hold", word_o, last_sent);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule